// File: doc/BRIEF.md
# Call and Return Stack-Frame Sequencer

This block carries out the memory side of subroutine linkage for a small 32-bit processor that keeps a frame pointer and a stack pointer in general registers. When the core issues a call, the sequencer builds a three-word frame below the current stack pointer. The upper word is left empty as a static-chain slot. The middle word receives the return address and the lower word receives the caller's frame pointer. It then reports the new frame pointer, stack pointer and program counter.

On a return it walks the frame the other way. It reads the saved frame pointer and the return address from the memory at the frame pointer. It then gives back a stack pointer that sits just past the static-chain slot.

Every transfer goes through one word-wide memory port with a request/ready handshake. A call comes in one of three forms: absolute target, register target, or a software trap that jumps through a vector input. The form selects both the return-address offset and the target source. The decoder that produces the requests lies outside this block.

Top module: `frame_seq`

## Requirements
- R1: After reset, mem_req_o, done_o and err_o are low and fp_o, sp_o and pc_o are zero.
- R2: A call with stack value S writes the return address to address S-8 and then the incoming frame pointer to S-12, in that order, with mem_we_o high. The static-chain word at S-4 is never accessed.
- R3: The return address written is call_pc_i+6 when call_kind_i is 2'b00 (absolute), 2'b10 (trap) or 2'b11, and call_pc_i+2 when call_kind_i is 2'b01 (register).
- R4: When a call completes, fp_o and sp_o both equal S-12, with 32-bit wraparound. pc_o equals trap_vec_i when call_kind_i is 2'b10 and target_i otherwise. All of these are values latched when the request was accepted.
- R5: A return with frame value F reads address F and then F+4 with mem_we_o low. It yields fp_o = first word read, pc_o = second word read and sp_o = F+12.
- R6: While mem_req_o is high and mem_ready_i is low, mem_addr_o, mem_we_o and mem_wdata_o hold steady. The sequence advances only on a clock edge where mem_ready_i is high.
- R7: done_o is high for exactly one cycle, the cycle after the edge that completes the final transfer. The new fp_o, sp_o and pc_o are visible in that same cycle.
- R8: call_i and ret_i are ignored while a sequence is in progress. No extra transfers occur and the results reflect only the accepted request.
- R9: A call whose sp_i has either of its two low bits set, or a return whose fp_i does, raises err_o for exactly one cycle after the request edge. No transfer is made, done_o stays low and fp_o, sp_o and pc_o keep their previous values.
- R10: If call_i and ret_i are both high in an idle cycle, the call is performed.
- R11: Whenever mem_req_o is high, the two low bits of mem_addr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call request, sampled when idle |
| ret_i | input | 1 | Return request, sampled when idle |
| call_kind_i | input | 2 | Call form: 00 absolute, 01 register, 10 trap, 11 as absolute |
| call_pc_i | input | 32 | Address of the call instruction |
| target_i | input | 32 | Target for absolute and register forms |
| trap_vec_i | input | 32 | Target for the trap form |
| fp_i | input | 32 | Current frame pointer |
| sp_i | input | 32 | Current stack pointer |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| fp_o | output | 32 | Frame pointer result |
| sp_o | output | 32 | Stack pointer result |
| pc_o | output | 32 | Program counter result |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle misaligned-pointer pulse |

## Verification
Calls are issued in all four kind encodings with distinct target and vector values. This shows whether the return offset and the target source follow the form rather than a fixed choice. Returns use saved words that differ from the frame address, so any swap between the two reads or use of the wrong base shows up.

A stack value of zero tests the wraparound of the frame arithmetic. Memory latency varies from back-to-back ready to long random stalls, which separates correct handshake holding from advancing on a timer. Requests asserted during a busy sequence, simultaneous call and return, and misaligned pointers cover the rejection paths.

Randomized mixes of calls and returns at random aligned addresses round out the set.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_RA = 3'd1,
    ST_PUSH_FP = 3'd2,
    ST_POP_FP  = 3'd3,
    ST_POP_RA  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    CK_ABS  = 2'b00,
    CK_REG  = 2'b01,
    CK_TRAP = 2'b10,
    CK_ALT  = 2'b11
  } call_kind_e;
endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  call_i,
  input  logic                  ret_i,
  input  logic [ALIGN_BITS-1:0] sp_lo_i,
  input  logic [ALIGN_BITS-1:0] fp_lo_i,
  input  logic                  mem_ready_i,
  output seq_state_e            state_o,
  output logic                  start_call_o,
  output logic                  start_ret_o,
  output logic                  finish_o,
  output logic                  done_o,
  output logic                  err_o
);
  seq_state_e state_q, state_d;
  logic       done_q, err_q;
  logic       idle, sp_bad, fp_bad, reject;

  assign idle   = (state_q == ST_IDLE);
  assign sp_bad = |sp_lo_i;
  assign fp_bad = |fp_lo_i;

  // call has priority over return
  assign start_call_o = idle && call_i && !sp_bad;
  assign start_ret_o  = idle && !call_i && ret_i && !fp_bad;
  assign reject       = idle && (call_i ? sp_bad : (ret_i && fp_bad));
  assign finish_o     = mem_ready_i && ((state_q == ST_PUSH_FP) || (state_q == ST_POP_RA));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_call_o)     state_d = ST_PUSH_RA;
        else if (start_ret_o) state_d = ST_POP_FP;
      end
      ST_PUSH_RA: if (mem_ready_i) state_d = ST_PUSH_FP;
      ST_PUSH_FP: if (mem_ready_i) state_d = ST_IDLE;
      ST_POP_FP:  if (mem_ready_i) state_d = ST_POP_RA;
      ST_POP_RA:  if (mem_ready_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_o;
      err_q   <= reject;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/frame_seq_addr.sv
module frame_seq_addr
  import frame_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4
) (
  input  seq_state_e      state_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] ret_addr_i,
  input  logic [XLEN-1:0] old_fp_i,
  output logic            req_o,
  output logic            we_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] wdata_o
);
  localparam logic [XLEN-1:0] OFS_RA = XLEN'(2 * WORD_BYTES);
  localparam logic [XLEN-1:0] OFS_FP = XLEN'(3 * WORD_BYTES);
  localparam logic [XLEN-1:0] OFS_W  = XLEN'(WORD_BYTES);

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b0;
    addr_o  = base_i;
    wdata_o = '0;
    unique case (state_i)
      ST_PUSH_RA: begin
        we_o    = 1'b1;
        addr_o  = base_i - OFS_RA;
        wdata_o = ret_addr_i;
      end
      ST_PUSH_FP: begin
        we_o    = 1'b1;
        addr_o  = base_i - OFS_FP;
        wdata_o = old_fp_i;
      end
      ST_POP_FP: addr_o = base_i;
      ST_POP_RA: addr_o = base_i + OFS_W;
      default: begin
        req_o  = 1'b0;
        addr_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int WORD_BYTES  = 4,
  parameter int LONG_BYTES  = 6,
  parameter int SHORT_BYTES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_state_e      state_i,
  input  logic            start_call_i,
  input  logic            start_ret_i,
  input  logic            finish_i,
  input  logic            mem_ready_i,
  input  logic [1:0]      call_kind_i,
  input  logic [XLEN-1:0] call_pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] trap_vec_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] base_o,
  output logic [XLEN-1:0] ret_addr_o,
  output logic [XLEN-1:0] old_fp_o,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] FRAME = XLEN'(3 * WORD_BYTES);

  logic [XLEN-1:0] base_q, ra_q, ofp_q, tgt_q, popped_fp_q;
  logic [XLEN-1:0] fp_q, sp_q, pc_q;
  logic [XLEN-1:0] ra_calc, tgt_calc;

  assign ra_calc  = call_pc_i + ((call_kind_e'(call_kind_i) == CK_REG) ?
                                 XLEN'(SHORT_BYTES) : XLEN'(LONG_BYTES));
  assign tgt_calc = (call_kind_e'(call_kind_i) == CK_TRAP) ? trap_vec_i : target_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      ra_q        <= '0;
      ofp_q       <= '0;
      tgt_q       <= '0;
      popped_fp_q <= '0;
    end else begin
      if (start_call_i) begin
        base_q <= sp_i;
        ra_q   <= ra_calc;
        ofp_q  <= fp_i;
        tgt_q  <= tgt_calc;
      end else if (start_ret_i) begin
        base_q <= fp_i;
      end
      if (state_i == ST_POP_FP && mem_ready_i) popped_fp_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q <= '0;
      sp_q <= '0;
      pc_q <= '0;
    end else if (finish_i) begin
      if (state_i == ST_PUSH_FP) begin
        fp_q <= base_q - FRAME;
        sp_q <= base_q - FRAME;
        pc_q <= tgt_q;
      end else begin
        fp_q <= popped_fp_q;
        sp_q <= base_q + FRAME;
        pc_q <= mem_rdata_i;
      end
    end
  end

  assign base_o     = base_q;
  assign ret_addr_o = ra_q;
  assign old_fp_o   = ofp_q;
  assign fp_o       = fp_q;
  assign sp_o       = sp_q;
  assign pc_o       = pc_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int WORD_BYTES  = 4,
  parameter int LONG_BYTES  = 6,
  parameter int SHORT_BYTES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [1:0]      call_kind_i,
  input  logic [XLEN-1:0] call_pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] trap_vec_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);

  seq_state_e      state;
  logic            start_call, start_ret, finish;
  logic [XLEN-1:0] base, ret_addr, old_fp;

  frame_seq_ctrl #(.ALIGN_BITS(ALIGN_BITS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .sp_lo_i      (sp_i[ALIGN_BITS-1:0]),
    .fp_lo_i      (fp_i[ALIGN_BITS-1:0]),
    .mem_ready_i  (mem_ready_i),
    .state_o      (state),
    .start_call_o (start_call),
    .start_ret_o  (start_ret),
    .finish_o     (finish),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  frame_seq_dp #(
    .XLEN(XLEN), .WORD_BYTES(WORD_BYTES),
    .LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)
  ) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .start_call_i (start_call),
    .start_ret_i  (start_ret),
    .finish_i     (finish),
    .mem_ready_i  (mem_ready_i),
    .call_kind_i  (call_kind_i),
    .call_pc_i    (call_pc_i),
    .target_i     (target_i),
    .trap_vec_i   (trap_vec_i),
    .fp_i         (fp_i),
    .sp_i         (sp_i),
    .mem_rdata_i  (mem_rdata_i),
    .base_o       (base),
    .ret_addr_o   (ret_addr),
    .old_fp_o     (old_fp),
    .fp_o         (fp_o),
    .sp_o         (sp_o),
    .pc_o         (pc_o)
  );

  frame_seq_addr #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_addr (
    .state_i    (state),
    .base_i     (base),
    .ret_addr_i (ret_addr),
    .old_fp_i   (old_fp),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o)
  );
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            mem_ready_i,
  input logic            done_o,
  input logic            err_o
);
  // R6
  hold_while_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  // R11
  addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R9
  err_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!mem_req_o && !done_o));

  // R9
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/sim_frame_seq.sv
`timescale 1ns/1ps
module sim_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 0, ret_i = 0;
  logic [1:0]  kind_i = 0;
  logic [31:0] pc_i = 0, tgt_i = 0, vec_i = 0, fp_i = 0, sp_i = 0;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] fp_o, sp_o, pc_o;
  logic        done_o, err_o;

  int tests = 0, fails = 0;
  int rdy_pct = 100;
  bit finished = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_addr[$];
  logic [31:0] log_data[$];
  bit          log_we[$];
  bit          hold_prev = 0;
  logic [31:0] prev_addr = 0;

  always #2.5 clk = ~clk;

  frame_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call_i), .ret_i(ret_i),
    .call_kind_i(kind_i), .call_pc_i(pc_i), .target_i(tgt_i), .trap_vec_i(vec_i),
    .fp_i(fp_i), .sp_i(sp_i), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .fp_o(fp_o), .sp_o(sp_o), .pc_o(pc_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ra(input logic [1:0] k, input logic [31:0] pc);
    return (k == 2'b01) ? pc + 32'd2 : pc + 32'd6;
  endfunction

  function automatic logic [31:0] exp_tgt(input logic [1:0] k, input logic [31:0] t,
                                          input logic [31:0] v);
    return (k == 2'b10) ? v : t;
  endfunction

  // memory responder, acts at the falling edge
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (hold_prev && mem_addr != prev_addr) begin
        tests++; fails++;
        $display("FAIL R6: actual=0x%08h expected=0x%08h", mem_addr, prev_addr);
      end
      if ($urandom_range(99) < rdy_pct) begin
        mem_ready = 1'b1;
        log_addr.push_back(mem_addr);
        log_we.push_back(mem_we);
        log_data.push_back(mem_wdata);
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        hold_prev = 0;
      end else begin
        mem_ready = 1'b0;
        hold_prev = 1;
        prev_addr = mem_addr;
      end
    end else begin
      mem_ready = 1'b0;
      hold_prev = 0;
    end
  end

  task automatic clear_log();
    log_addr.delete(); log_we.delete(); log_data.delete();
  endtask

  // wait for done_o, sampling at falling edges; poke = drive requests while busy
  task automatic wait_done(input bit poke, output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin got = 1; break; end
      if (poke) begin
        call_i = 1; ret_i = 1; kind_i = 2'($urandom);
        sp_i = $urandom & ~32'h3; fp_i = $urandom & ~32'h3;
        pc_i = $urandom; tgt_i = $urandom; vec_i = $urandom;
      end
      @(negedge clk);
      if (done_o) begin call_i = 0; ret_i = 0; end
    end
    call_i = 0; ret_i = 0;
  endtask

  task automatic do_call(input logic [1:0] k, input logic [31:0] pc, tgt, vec, fp, sp,
                         input bit both, input bit poke);
    bit got;
    logic [31:0] ns;
    clear_log();
    @(negedge clk);
    kind_i = k; pc_i = pc; tgt_i = tgt; vec_i = vec; fp_i = fp; sp_i = sp;
    call_i = 1; ret_i = both;
    @(negedge clk);
    call_i = 0; ret_i = 0;
    wait_done(poke, got);
    ns = sp - 32'd12;
    chk("R7 done seen", 32'(got), 32'd1);
    chk("R4 sp_o", sp_o, ns);
    chk("R4 fp_o", fp_o, ns);
    chk("R4 pc_o", pc_o, exp_tgt(k, tgt, vec));
    chk(poke ? "R8 transfer count" : (both ? "R10 transfer count" : "R2 transfer count"),
        32'(log_addr.size()), 32'd2);
    if (log_addr.size() == 2) begin
      chk("R2 first addr", log_addr[0], sp - 32'd8);
      chk("R2 first write", 32'(log_we[0]), 32'd1);
      chk("R3 return address", log_data[0], exp_ra(k, pc));
      chk("R2 second addr", log_addr[1], ns);
      chk("R2 second write", 32'(log_we[1]), 32'd1);
      chk("R2 saved fp", log_data[1], fp);
    end
    @(negedge clk);
    chk("R7 done one cycle", 32'(done_o), 32'd0);
  endtask

  task automatic do_ret(input logic [31:0] fp, saved_fp, ra, input bit poke);
    bit got;
    mem[fp] = saved_fp;
    mem[fp + 32'd4] = ra;
    clear_log();
    @(negedge clk);
    fp_i = fp; sp_i = $urandom; ret_i = 1;
    @(negedge clk);
    ret_i = 0;
    wait_done(poke, got);
    chk("R7 done seen", 32'(got), 32'd1);
    chk("R5 fp_o", fp_o, saved_fp);
    chk("R5 pc_o", pc_o, ra);
    chk("R5 sp_o", sp_o, fp + 32'd12);
    chk(poke ? "R8 transfer count" : "R5 transfer count", 32'(log_addr.size()), 32'd2);
    if (log_addr.size() == 2) begin
      chk("R5 first addr", log_addr[0], fp);
      chk("R5 second addr", log_addr[1], fp + 32'd4);
      chk("R5 reads", 32'(log_we[0] | log_we[1]), 32'd0);
    end
    @(negedge clk);
    chk("R7 done one cycle", 32'(done_o), 32'd0);
  endtask

  task automatic do_bad(input bit is_call, input logic [1:0] lo);
    logic [31:0] f0, s0, p0;
    f0 = fp_o; s0 = sp_o; p0 = pc_o;
    clear_log();
    @(negedge clk);
    sp_i = 32'h0000_8000 | 32'(lo); fp_i = 32'h0000_9000 | 32'(lo);
    call_i = is_call; ret_i = !is_call;
    @(negedge clk);
    call_i = 0; ret_i = 0;
    chk("R9 err raised", 32'(err_o), 32'd1);
    chk("R9 no request", 32'(mem_req), 32'd0);
    @(negedge clk);
    chk("R9 err one cycle", 32'(err_o), 32'd0);
    repeat (4) begin
      @(negedge clk);
      if (done_o || mem_req) chk("R9 stays idle", 32'(done_o | mem_req), 32'd0);
    end
    chk("R9 no transfers", 32'(log_addr.size()), 32'd0);
    chk("R9 fp kept", fp_o, f0);
    chk("R9 sp kept", sp_o, s0);
    chk("R9 pc kept", pc_o, p0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 req", 32'(mem_req), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 err", 32'(err_o), 32'd0);
    chk("R1 fp", fp_o, 32'd0);
    chk("R1 sp", sp_o, 32'd0);
    chk("R1 pc", pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    rdy_pct = 100;
    do_call(2'b00, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 32'h0000_7F00, 32'h0000_8000, 0, 0);
    do_call(2'b01, 32'h0000_1100, 32'h0000_2200, 32'h0000_3300, 32'h0000_7E00, 32'h0000_7F00, 0, 0);
    rdy_pct = 30;
    do_call(2'b10, 32'h0000_1200, 32'h0000_2400, 32'h0000_3600, 32'h0000_7D00, 32'h0000_7E00, 0, 0);
    do_call(2'b11, 32'h0000_1300, 32'h0000_2600, 32'h0000_3900, 32'h0000_7C00, 32'h0000_7D00, 0, 0);
    // stack wraparound at zero
    do_call(2'b00, 32'hFFFF_FFFC, 32'h0000_0040, 32'h0, 32'h0000_0100, 32'h0000_0000, 0, 0);
    do_ret(32'h0000_6000, 32'h0000_6100, 32'h0000_1234, 0);
    rdy_pct = 100;
    do_ret(32'hFFFF_FFF8, 32'hAAAA_0000, 32'h5555_0006, 0);
    // R10 simultaneous
    do_call(2'b01, 32'h0000_4000, 32'h0000_5000, 32'h0, 32'h0000_A000, 32'h0000_B000, 1, 0);
    // R8 busy requests ignored
    rdy_pct = 20;
    do_call(2'b00, 32'h0000_4400, 32'h0000_5500, 32'h0, 32'h0000_C000, 32'h0000_D000, 0, 1);
    do_ret(32'h0000_E000, 32'h0000_E100, 32'h0000_ABCD, 1);
    // R9 misaligned
    do_bad(1, 2'b10);
    do_bad(0, 2'b01);
    do_bad(1, 2'b01);

    for (int n = 0; n < 40; n++) begin
      rdy_pct = 10 + $urandom_range(90);
      if ($urandom_range(1)) begin
        do_call(2'($urandom), $urandom, $urandom, $urandom, $urandom,
                $urandom & ~32'h3, 0, 0);
      end else begin
        do_ret($urandom & ~32'h3, $urandom, $urandom, 0);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule